// File: doc/BRIEF.md
# Block Cipher Register Front End

This block is the memory-mapped control side of a 128-bit block cipher engine. Software, or a DMA engine, reaches it through a simple single-cycle 32-bit bus. The bus gives access to eight key words, four chaining-value words, a control register, a four-word data window, a revision register, a configuration mask and a status register. The cipher rounds are not part of this block. A whole 128-bit block goes to an external core over a valid/ready port, and the result returns over a second valid/ready port. The front end also performs the block chaining for chained-block mode, so the core only ever performs a plain single-block transform.

The sequencing is set by one state machine with five states:

- **IDLE**: the window accepts input.
- **SEND**: a block is offered to the core.
- **WAIT**: the front end waits for the result.
- **HOLD**: a result is held in the window.
- **SRST**: the soft reset is counting.

The transitions are:

- IDLE→SEND: a write to the last window word at 0x40.
- SEND→WAIT: the core accepts the block.
- WAIT→HOLD: the result is captured.
- HOLD→IDLE: the last window word at 0x40 is read.
- Any state→SRST: the soft-reset bit is written.
- SRST→IDLE: the fixed count has expired.

DMA requests are level signals. The input request asks for four words while the window is empty. The output request asks for four words while a result is held.

Top module: `blkc_front`

## Requirements
- R1: Key word n is written and read at byte offset 0x1C − 4·(n XOR 1), so word 0 is at 0x18, word 1 at 0x1C and word 7 at 0x04. Word n appears on `core_key` bits [32n+31:32n].
- R2: The four chaining-value words sit at 0x20, 0x24, 0x28 and 0x2C and read back as written. The control register at 0x30 stores bits 7:2 as written. Bit 1 reads input-ready and bit 0 reads output-ready. After reset the control register reads 0x02.
- R3: Control bit 2 (1 = encrypt) drives `core_encrypt`. Control bits 4:3 hold the key-size code (key bytes / 8) − 1 and drive `core_key_size`.
- R4: Offset 0x44 reads {REV_MAJOR in bits 7:4, REV_MINOR in bits 3:0}.
- R5: The mask register at 0x48 stores auto-idle (bit 0), DMA-in enable (bit 2), DMA-out enable (bit 3), start (bit 5) and smart-idle (bit 6). The soft-reset bit (bit 1) and the other bits always read 0.
- R6: Writing 1 to mask bit 1 clears the key, chaining value, control, mask and window. Status bit 0 at 0x4C then reads 0 for RST_CYCLES cycles and returns to 1. While it is 0, every read returns 0 and every write is ignored.
- R7: Input-ready is 1 only while the window is empty. Writing window word 3 at 0x40 launches the block. Window writes made while the window is not empty are ignored.
- R8: `core_valid` stays high with `core_blk` stable until `core_ready`. Then `res_ready` is raised until `res_valid`. The two phases never overlap.
- R9: Output-ready is 1 while a result is held in the window, words 0..3 at 0x34..0x40. Reading 0x40 frees the window and raises input-ready again.
- R10: `dma_in_req` is high only while input-ready, start and DMA-in enable are all set. `dma_out_req` is high only while output-ready, start and DMA-out enable are all set.
- R11: With control bit 5 clear (plain block mode), the window block goes to the core unchanged, the result is returned unchanged and the chaining value is not modified.
- R12: In chained-block encryption (bits 5 and 2 set), the core receives the data XOR the chaining value. The result is returned and also replaces the chaining value.
- R13: In chained-block decryption (bit 5 set, bit 2 clear), the core receives the data. The result XOR the chaining value is returned, and the input block replaces the chaining value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (side effect only on 0x40) |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| dma_in_req | output | 1 | DMA request to fill the window |
| dma_out_req | output | 1 | DMA request to drain the window |
| core_valid | output | 1 | Block offered to the core |
| core_ready | input | 1 | Core accepts the block |
| core_blk | output | 128 | Block to the core, word k in bits [32k+31:32k] |
| core_key | output | 256 | Key words to the core |
| core_key_size | output | 2 | Key-size code |
| core_encrypt | output | 1 | 1 = encrypt |
| res_valid | input | 1 | Core result valid |
| res_ready | output | 1 | Front end takes the result |
| res_blk | input | 128 | Core result block |

## Verification
The core is modelled as a bitwise inversion, which is its own inverse. Plain-block encryption is run with a non-zero chaining value, which shows whether that value leaks into the data or gets modified. Two chained encryptions are then run back to back, followed by two decryptions of their outputs from the original chaining value. Recovering the plaintexts separates correct chaining in each direction from swapped or missing XORs. The key-offset test writes a distinct value to every word, which exposes any error in the pair swap. The soft-reset test reads status on each cycle to pin down the exact length of the quiet window.

// File: rtl/blkc_pkg.sv
package blkc_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int KEY_WORDS = 8;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int KEY_W     = WORD_W * KEY_WORDS;

    localparam logic [7:0] OFS_IV0   = 8'h20;
    localparam logic [7:0] OFS_CTRL  = 8'h30;
    localparam logic [7:0] OFS_WIN0  = 8'h34;
    localparam logic [7:0] OFS_WIN3  = 8'h40;
    localparam logic [7:0] OFS_REV   = 8'h44;
    localparam logic [7:0] OFS_MASK  = 8'h48;
    localparam logic [7:0] OFS_STAT  = 8'h4C;

    localparam int CT_DIR = 2;
    localparam int CT_CBC = 5;

    localparam int MK_SRST = 1;
    localparam int MK_DIN  = 2;
    localparam int MK_DOUT = 3;
    localparam int MK_GO   = 5;
    localparam logic [7:0] MASK_WMASK = 8'h6D;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_HOLD,
        ST_SRST
    } fe_state_t;
endpackage

// File: rtl/blkc_chain.sv
module blkc_chain #(
    parameter int BW = 128
) (
    input  logic          cbc,
    input  logic          enc,
    input  logic [BW-1:0] win_blk,
    input  logic [BW-1:0] iv_blk,
    input  logic [BW-1:0] res_blk,
    output logic [BW-1:0] core_in,
    output logic [BW-1:0] out_blk,
    output logic [BW-1:0] iv_next
);
    // encrypt chains before the core, decrypt chains after it
    assign core_in = (cbc && enc)  ? (win_blk ^ iv_blk) : win_blk;
    assign out_blk = (cbc && !enc) ? (res_blk ^ iv_blk) : res_blk;
    assign iv_next = enc ? res_blk : win_blk;
endmodule

// File: rtl/blkc_rdmux.sv
module blkc_rdmux
    import blkc_pkg::*;
(
    input  logic [7:0]        addr,
    input  logic              quiet,
    input  logic [KEY_W-1:0]  key_flat,
    input  logic [BLK_W-1:0]  iv_flat,
    input  logic [BLK_W-1:0]  win_flat,
    input  logic [7:0]        ctrl_rd,
    input  logic [7:0]        mask_rd,
    input  logic [7:0]        rev_rd,
    input  logic              stat_done,
    output logic [WORD_W-1:0] rdata
);
    logic [2:0] kidx;
    logic [1:0] widx;
    logic       aligned;

    assign kidx    = (~addr[4:2]) ^ 3'd1;
    assign widx    = addr[3:2] - 2'd1;
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        rdata = '0;
        if (!quiet && aligned) begin
            if (addr < OFS_IV0)
                rdata = key_flat[int'(kidx)*WORD_W +: WORD_W];
            else if (addr[7:4] == 4'h2)
                rdata = iv_flat[int'(addr[3:2])*WORD_W +: WORD_W];
            else if (addr == OFS_CTRL)
                rdata = {24'd0, ctrl_rd};
            else if (addr >= OFS_WIN0 && addr <= OFS_WIN3)
                rdata = win_flat[int'(widx)*WORD_W +: WORD_W];
            else if (addr == OFS_REV)
                rdata = {24'd0, rev_rd};
            else if (addr == OFS_MASK)
                rdata = {24'd0, mask_rd};
            else if (addr == OFS_STAT)
                rdata = {31'd0, stat_done};
        end
    end
endmodule

// File: rtl/blkc_front.sv
module blkc_front
    import blkc_pkg::*;
#(
    parameter int REV_MAJOR  = 3,
    parameter int REV_MINOR  = 2,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              dma_in_req,
    output logic              dma_out_req,
    output logic              core_valid,
    input  logic              core_ready,
    output logic [BLK_W-1:0]  core_blk,
    output logic [KEY_W-1:0]  core_key,
    output logic [1:0]        core_key_size,
    output logic              core_encrypt,
    input  logic              res_valid,
    output logic              res_ready,
    input  logic [BLK_W-1:0]  res_blk
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);
    localparam logic [7:0] REV_BYTE = {4'(REV_MAJOR), 4'(REV_MINOR)};

    fe_state_t st_q, st_d;

    logic [WORD_W-1:0] key_q [KEY_WORDS];
    logic [WORD_W-1:0] iv_q  [BLK_WORDS];
    logic [WORD_W-1:0] win_q [BLK_WORDS];
    logic [7:2]        ctrl_q;
    logic [7:0]        mask_q;
    logic [CNT_W-1:0]  cnt_q;

    logic rst_busy, in_rdy, out_rdy;
    logic wr_ok, aligned, hit_key, hit_iv, hit_win;
    logic srst_req, launch, release_win, res_take;
    logic [2:0] key_idx;
    logic [1:0] win_idx;

    logic [KEY_W-1:0] key_flat;
    logic [BLK_W-1:0] iv_flat, win_flat, chain_out, iv_upd;

    // decode
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_ok    = bus_wr && !rst_busy && aligned;
    assign hit_key  = (bus_addr < OFS_IV0);
    assign hit_iv   = (bus_addr[7:4] == 4'h2);
    assign hit_win  = (bus_addr >= OFS_WIN0) && (bus_addr <= OFS_WIN3);
    assign key_idx  = (~bus_addr[4:2]) ^ 3'd1;
    assign win_idx  = bus_addr[3:2] - 2'd1;

    assign srst_req    = wr_ok && (bus_addr == OFS_MASK) && bus_wdata[MK_SRST];
    assign launch      = wr_ok && hit_win && (win_idx == 2'd3) && in_rdy;
    assign release_win = bus_rd && !rst_busy && (bus_addr == OFS_WIN3) && out_rdy;
    assign res_take    = res_valid && res_ready;

    for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
        assign key_flat[k*WORD_W +: WORD_W] = key_q[k];
    end
    for (genvar k = 0; k < BLK_WORDS; k++) begin : g_blk
        assign iv_flat[k*WORD_W +: WORD_W]  = iv_q[k];
        assign win_flat[k*WORD_W +: WORD_W] = win_q[k];
    end

    blkc_chain #(.BW(BLK_W)) u_chain (
        .cbc     (ctrl_q[CT_CBC]),
        .enc     (ctrl_q[CT_DIR]),
        .win_blk (win_flat),
        .iv_blk  (iv_flat),
        .res_blk (res_blk),
        .core_in (core_blk),
        .out_blk (chain_out),
        .iv_next (iv_upd)
    );

    blkc_rdmux u_rdmux (
        .addr      (bus_addr),
        .quiet     (rst_busy),
        .key_flat  (key_flat),
        .iv_flat   (iv_flat),
        .win_flat  (win_flat),
        .ctrl_rd   ({ctrl_q, in_rdy, out_rdy}),
        .mask_rd   (mask_q),
        .rev_rd    (REV_BYTE),
        .stat_done (!rst_busy),
        .rdata     (bus_rdata)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (launch)              st_d = ST_SEND;
            ST_SEND: if (core_ready)          st_d = ST_WAIT;
            ST_WAIT: if (res_valid)           st_d = ST_HOLD;
            ST_HOLD: if (release_win)         st_d = ST_IDLE;
            ST_SRST: if (cnt_q == CNT_LAST)   st_d = ST_IDLE;
            default:                          st_d = ST_IDLE;
        endcase
        if (srst_req) st_d = ST_SRST;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        in_rdy     = 1'b0;
        out_rdy    = 1'b0;
        core_valid = 1'b0;
        res_ready  = 1'b0;
        rst_busy   = 1'b0;
        unique case (st_q)
            ST_IDLE: in_rdy     = 1'b1;
            ST_SEND: core_valid = 1'b1;
            ST_WAIT: res_ready  = 1'b1;
            ST_HOLD: out_rdy    = 1'b1;
            ST_SRST: rst_busy   = 1'b1;
            default: ;
        endcase
        dma_in_req  = in_rdy  && mask_q[MK_GO] && mask_q[MK_DIN];
        dma_out_req = out_rdy && mask_q[MK_GO] && mask_q[MK_DOUT];
    end

    assign core_key      = key_flat;
    assign core_key_size = ctrl_q[4:3];
    assign core_encrypt  = ctrl_q[CT_DIR];

    // register storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || srst_req) begin
            for (int i = 0; i < KEY_WORDS; i++) key_q[i] <= '0;
            for (int i = 0; i < BLK_WORDS; i++) begin
                iv_q[i]  <= '0;
                win_q[i] <= '0;
            end
            ctrl_q <= '0;
            mask_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (st_q == ST_SRST) cnt_q <= cnt_q + 1'b1;
            if (wr_ok) begin
                if (hit_key)                key_q[key_idx]            <= bus_wdata;
                if (hit_iv)                 iv_q[bus_addr[3:2]]       <= bus_wdata;
                if (bus_addr == OFS_CTRL)   ctrl_q                    <= bus_wdata[7:2];
                if (bus_addr == OFS_MASK)   mask_q                    <= bus_wdata[7:0] & MASK_WMASK;
                if (hit_win && in_rdy)      win_q[win_idx]            <= bus_wdata;
            end
            if (res_take) begin
                for (int i = 0; i < BLK_WORDS; i++) begin
                    win_q[i] <= chain_out[i*WORD_W +: WORD_W];
                    if (ctrl_q[CT_CBC]) iv_q[i] <= iv_upd[i*WORD_W +: WORD_W];
                end
            end
        end
    end
endmodule

// File: rtl/blkc_front_chk.sv
module blkc_front_chk #(
    parameter int RST_CYCLES = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic [7:0]   bus_addr,
    input logic         srst_bit,
    input logic [31:0]  bus_rdata,
    input logic         dma_in_req,
    input logic         dma_out_req,
    input logic         core_valid,
    input logic         core_ready,
    input logic [127:0] core_blk,
    input logic         res_valid,
    input logic         res_ready,
    input logic         rst_busy
);
    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        busy_run <= 0;
        else if (rst_busy) busy_run <= busy_run + 1;
        else               busy_run <= 0;
    end

    AST_SRST_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !rst_busy && bus_addr == 8'h48 && srst_bit |=> rst_busy); // R6
    AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |-> bus_rdata == 32'd0); // R6
    AST_SRST_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |-> busy_run < RST_CYCLES); // R6
    AST_DMA_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_in_req && dma_out_req)); // R10
    AST_CORE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid && !core_ready && !bus_wr |=> core_valid && $stable(core_blk)); // R8
    AST_PHASE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_valid && res_ready)); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_ready |=> !res_ready && !core_valid); // R9
endmodule

bind blkc_front blkc_front_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .srst_bit    (bus_wdata[1]),
    .bus_rdata   (bus_rdata),
    .dma_in_req  (dma_in_req),
    .dma_out_req (dma_out_req),
    .core_valid  (core_valid),
    .core_ready  (core_ready),
    .core_blk    (core_blk),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .rst_busy    (rst_busy)
);

// File: tb/tb_blkc_front.sv
module tb_blkc_front;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         dma_in_req, dma_out_req;
    logic         core_valid, core_ready;
    logic [127:0] core_blk;
    logic [255:0] core_key;
    logic [1:0]   core_key_size;
    logic         core_encrypt;
    logic         res_valid, res_ready;
    logic [127:0] res_blk;
    logic [127:0] seen_blk;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkc_front dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
        .core_valid(core_valid), .core_ready(core_ready), .core_blk(core_blk),
        .core_key(core_key), .core_key_size(core_key_size), .core_encrypt(core_encrypt),
        .res_valid(res_valid), .res_ready(res_ready), .res_blk(res_blk)
    );

    // stand-in core: bitwise inversion, a few cycles of latency
    initial begin
        core_ready = 1'b0;
        res_valid  = 1'b0;
        res_blk    = '0;
        seen_blk   = '0;
        forever begin
            @(negedge clk);
            if (core_valid) begin
                repeat (2) @(negedge clk);
                core_ready = 1'b1;
                seen_blk   = core_blk;
                @(negedge clk);
                core_ready = 1'b0;
                @(negedge clk);
                res_blk   = ~seen_blk;
                res_valid = 1'b1;
                while (!res_ready) @(negedge clk);
                @(negedge clk);
                res_valid = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic send_blk(input logic [127:0] d);
        for (int k = 0; k < 4; k++) wr(8'h34 + 8'(4*k), d[32*k +: 32]);
    endtask

    task automatic wait_out(input string req);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 40; i++) begin
            rd(8'h30, v);
            if (v[0]) break;
        end
        chk(req, {31'd0, v[0]}, 32'd1);
    endtask

    task automatic read_blk(output logic [127:0] r);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            rd(8'h34 + 8'(4*k), v);
            r[32*k +: 32] = v;
        end
    endtask

    task automatic read_iv(output logic [127:0] r);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            rd(8'h20 + 8'(4*k), v);
            r[32*k +: 32] = v;
        end
    endtask

    task automatic write_iv(input logic [127:0] v);
        for (int k = 0; k < 4; k++) wr(8'h20 + 8'(4*k), v[32*k +: 32]);
    endtask

    task automatic chk_blk(input string req, input logic [127:0] act, input logic [127:0] exp);
        for (int k = 0; k < 4; k++) chk(req, act[32*k +: 32], exp[32*k +: 32]);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h30, v); chk("R2 ctrl after reset", v, 32'h02);
        rd(8'h4C, v); chk("R6 status after reset", v, 32'h1);
        rd(8'h44, v); chk("R4 revision", v, 32'h32);
        rd(8'h48, v); chk("R5 mask after reset", v, 32'h0);
        chk("R8 core_valid idle", {31'd0, core_valid}, 32'd0);
        chk("R10 no dma at reset", {30'd0, dma_in_req, dma_out_req}, 32'd0);
    endtask

    task automatic t_keymap;
        logic [31:0] v;
        for (int n = 0; n < 8; n++) wr(8'h1C - 8'(4*(n ^ 1)), 32'hC0DE_0000 | n);
        for (int n = 0; n < 8; n++) chk("R1 key port word", core_key[32*n +: 32], 32'hC0DE_0000 | n);
        rd(8'h18, v); chk("R1 word0 at 0x18", v, 32'hC0DE_0000);
        rd(8'h04, v); chk("R1 word7 at 0x04", v, 32'hC0DE_0007);
        wr(8'h30, 32'h14);
        chk("R3 key size code", {30'd0, core_key_size}, 32'd2);
        chk("R3 direction", {31'd0, core_encrypt}, 32'd1);
        rd(8'h30, v); chk("R2 ctrl readback", v, 32'h16);
    endtask

    task automatic t_iv_mask;
        logic [127:0] r;
        logic [31:0]  v;
        write_iv(128'h0F0E0D0C_0B0A0908_07060504_03020100);
        read_iv(r); chk_blk("R2 iv readback", r, 128'h0F0E0D0C_0B0A0908_07060504_03020100);
        wr(8'h48, 32'hFFFF_FFFD);
        rd(8'h48, v); chk("R5 mask bits", v, 32'h6D);
        wr(8'h48, 32'h0);
    endtask

    task automatic t_ecb;
        logic [127:0] d, r;
        d = 128'h01234567_89ABCDEF_FEDCBA98_76543210;
        wr(8'h30, 32'h0C);
        write_iv(128'h11111111_22222222_33333333_44444444);
        send_blk(d);
        wait_out("R9 output ready");
        chk_blk("R8 core saw data", seen_blk, d);
        wr(8'h34, 32'hBAD0_BAD0);
        read_blk(r);
        chk_blk("R11 ecb result", r, ~d);
        rd(8'h30, r[31:0]); chk("R9 window freed", r[31:0], 32'h0E);
        read_iv(r); chk_blk("R11 iv untouched", r, 128'h11111111_22222222_33333333_44444444);
        wr(8'h34, 32'hAAAA_0001);
        rd(8'h34, r[31:0]); chk("R7 window write when empty", r[31:0], 32'hAAAA_0001);
    endtask

    task automatic t_cbc;
        logic [127:0] iv0, p1, p2, c1, c2, r;
        iv0 = 128'hA5A5A5A5_5A5A5A5A_0F0F0F0F_F0F0F0F0;
        p1  = 128'h00000001_00000002_00000003_00000004;
        p2  = 128'hDEADBEEF_CAFEF00D_12345678_9ABCDEF0;
        c1  = ~(p1 ^ iv0);
        c2  = ~(p2 ^ c1);
        wr(8'h30, 32'h2C);
        write_iv(iv0);
        send_blk(p1); wait_out("R12 first block");
        chk_blk("R12 core input chained", seen_blk, p1 ^ iv0);
        read_blk(r);  chk_blk("R12 cipher 1", r, c1);
        read_iv(r);   chk_blk("R12 iv rolled", r, c1);
        send_blk(p2); wait_out("R12 second block");
        read_blk(r);  chk_blk("R12 cipher 2", r, c2);
        wr(8'h30, 32'h28);
        write_iv(iv0);
        send_blk(c1); wait_out("R13 first block");
        chk_blk("R13 core input plain", seen_blk, c1);
        read_blk(r);  chk_blk("R13 plain 1", r, p1);
        read_iv(r);   chk_blk("R13 iv from input", r, c1);
        send_blk(c2); wait_out("R13 second block");
        read_blk(r);  chk_blk("R13 plain 2", r, p2);
    endtask

    task automatic t_dma;
        logic [127:0] r;
        wr(8'h30, 32'h0C);
        wr(8'h48, 32'h0C);
        chk("R10 no start no in req", {31'd0, dma_in_req}, 32'd0);
        wr(8'h48, 32'h2C);
        chk("R10 in req when empty", {31'd0, dma_in_req}, 32'd1);
        chk("R10 out req quiet", {31'd0, dma_out_req}, 32'd0);
        send_blk(128'h5);
        chk("R7 input ready low while busy", {31'd0, dma_in_req}, 32'd0);
        wait_out("R9 dma block");
        chk("R10 out req when held", {31'd0, dma_out_req}, 32'd1);
        chk("R10 in req off when held", {31'd0, dma_in_req}, 32'd0);
        read_blk(r);
        chk("R10 out req cleared", {31'd0, dma_out_req}, 32'd0);
        wr(8'h48, 32'h0);
    endtask

    task automatic t_srst;
        logic [31:0] v;
        wr(8'h18, 32'h1234_5678);
        wr(8'h20, 32'h9999_0000);
        wr(8'h30, 32'h2C);
        wr(8'h48, 32'h2C);
        wr(8'h48, 32'h02);
        for (int i = 0; i < 4; i++) begin
            rd(8'h4C, v); chk("R6 status low during reset", v, 32'h0);
        end
        rd(8'h4C, v); chk("R6 status back to done", v, 32'h1);
        rd(8'h18, v); chk("R6 key cleared", v, 32'h0);
        rd(8'h20, v); chk("R6 iv cleared", v, 32'h0);
        rd(8'h30, v); chk("R6 ctrl cleared", v, 32'h02);
        rd(8'h48, v); chk("R6 mask cleared", v, 32'h0);
        wr(8'h48, 32'h02);
        wr(8'h18, 32'hDEAD_BEEF);
        repeat (6) @(negedge clk);
        rd(8'h18, v); chk("R6 write ignored in reset", v, 32'h0);
        chk("R6 key port clear", core_key[31:0], 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_keymap();
        t_iv_mask();
        t_ecb();
        t_cbc();
        t_dma();
        t_srst();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule